// File: doc/BRIEF.md
# Loop Block Prefetch and Cache Lock Controller

This controller sits beside an instruction cache in a multi-threaded pipeline that synchronises its threads on hot loops. When the first thread reaches a selected loop, the controller is started with the loop's first and last memory block addresses. It then fetches every block of that range from memory into a small staging buffer. Because the blocks are fetched by address and not by execution, branches inside the loop that no thread has taken yet are still covered.

Blocks wait in the buffer until every participating thread has assembled at the loop head. This keeps other threads from evicting them before the loop starts. After that point the buffer drains one block per cycle into the cache, and new memory requests refill the freed entries at the same time. Once the last block of the range has been written into the cache, the controller raises the lock enable, which protects that cache segment. The lock enable drops when all threads report that the loop is finished. A start request that arrives while a prefetch or a lock is in progress is ignored.

Top module: `loop_prefetch_lock`

## Requirements
- R1: After reset, req_valid_o, cwr_valid_o and lock_en_o are all low.
- R2: A start_i pulse while idle captures first_blk_i and last_blk_i (last not below first). The controller then requests every block from first to last inclusive, exactly once each, in ascending order, with the address rising by one after each request.
- R3: req_valid_o is high only in a cycle where mem_busy_i is low and no request of its own is awaiting rsp_valid_i, so at most one request is outstanding.
- R4: The staging buffer holds BUF_BYTES/BLK_BYTES blocks (4 with the defaults of 32 and 8). A request is made only while buffered blocks plus the outstanding request number fewer than that. Before assembly, therefore, at most 4 blocks are requested.
- R5: No cache write (cwr_valid_o) occurs until assembled_i has been seen high at a clock edge. Writes come out in ascending address order from the first block, at most one per cycle. Each cwr_data_o equals the rsp_data_i returned for that address.
- R6: After assembly, draining and new requests run concurrently, so every block of a range longer than the buffer is written into the cache.
- R7: lock_en_o rises in the cycle after the cache write of the last block, and never earlier.
- R8: With lock_en_o high, done_i high at a clock edge clears lock_en_o in the next cycle. The controller then becomes idle and accepts a new start.
- R9: start_i is ignored while a prefetch or lock is active. The range and request sequence of the current run are unchanged.
- R10: A range of a single block (first equal to last) makes one request and one write, then locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse from the thread assembly logic |
| first_blk_i | input | AW | First block address of the loop |
| last_blk_i | input | AW | Last block address of the loop |
| mem_busy_i | input | 1 | A memory read is in progress |
| req_valid_o | output | 1 | Block read request issued this cycle |
| req_addr_o | output | AW | Block address of the request |
| rsp_valid_i | input | 1 | Requested block returns from memory |
| rsp_data_i | input | BLK_BYTES*8 | Returned block contents |
| assembled_i | input | 1 | All participating threads reached the loop head |
| done_i | input | 1 | All participating threads finished the loop |
| cwr_valid_o | output | 1 | Cache write of one block this cycle |
| cwr_addr_o | output | AW | Block address being written into the cache |
| cwr_data_o | output | BLK_BYTES*8 | Block contents being written |
| lock_en_o | output | 1 | Cache segment lock enable |

## Verification
Random runs vary the range start and length, the delay before assembly, the memory latency and how often memory is busy. Busy and latency patterns separate correct throttling from a controller that ignores the memory state. The assembly delay separates buffering from early draining. A long directed delay with an eight-block range shows that requests stop once the four-entry buffer is full, and that refill while draining covers blocks beyond the buffer size. Directed single-block, top-of-address-space and start-while-active cases exercise counter boundaries and the ignore rule.

// File: rtl/lpl_pkg.sv
package lpl_pkg;
   typedef enum logic [1:0] {
      LPL_IDLE = 2'd0,
      LPL_FILL = 2'd1,
      LPL_LOCK = 2'd2
   } lpl_state_e;
endpackage

// File: rtl/lpl_fifo.sv
module lpl_fifo #(
   parameter int DW    = 64,
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push_i,
   input  logic [DW-1:0] din_i,
   input  logic          pop_i,
   output logic [DW-1:0] dout_o,
   output logic          empty_o,
   output logic [CW-1:0] count_o
);
   if (DEPTH == 1) begin : g_single
      logic [DW-1:0] slot_q;
      logic          full_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) full_q <= 1'b0;
         else if (push_i && (!full_q || pop_i)) full_q <= 1'b1;
         else if (pop_i) full_q <= 1'b0;
      end
      always_ff @(posedge clk) begin
         if (push_i && (!full_q || pop_i)) slot_q <= din_i;
      end
      assign dout_o  = slot_q;
      assign empty_o = !full_q;
      assign count_o = CW'(full_q);
   end else begin : g_ring
      localparam int PW = $clog2(DEPTH);
      logic [DW-1:0] mem_q [DEPTH];
      logic [PW-1:0] wp_q, rp_q;
      logic [CW-1:0] cnt_q;
      logic          do_push, do_pop;
      assign do_pop  = pop_i && (cnt_q != '0);
      assign do_push = push_i && ((cnt_q != CW'(DEPTH)) || do_pop);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (do_push) wp_q <= wp_q + PW'(1);
            if (do_pop)  rp_q <= rp_q + PW'(1);
            case ({do_push, do_pop})
               2'b10:   cnt_q <= cnt_q + CW'(1);
               2'b01:   cnt_q <= cnt_q - CW'(1);
               default: cnt_q <= cnt_q;
            endcase
         end
      end
      always_ff @(posedge clk) begin
         if (do_push) mem_q[wp_q] <= din_i;
      end
      assign dout_o  = mem_q[rp_q];
      assign empty_o = (cnt_q == '0);
      assign count_o = cnt_q;
   end
endmodule

// File: rtl/lpl_issuer.sv
module lpl_issuer #(
   parameter int AW    = 16,
   parameter int DEPTH = 4,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] first_i,
   input  logic [AW-1:0] last_i,
   input  logic          mem_busy_i,
   input  logic [CW-1:0] buf_cnt_i,
   input  logic          ack_i,
   output logic          req_valid_o,
   output logic [AW-1:0] req_addr_o,
   output logic          outst_o
);
   logic [AW-1:0] next_q;
   logic [AW:0]   left_q;
   logic          outst_q;
   logic [CW:0]   occ;
   logic          room;

   assign occ  = {1'b0, buf_cnt_i} + {{CW{1'b0}}, outst_q};
   assign room = (occ < (CW+1)'(DEPTH));
   assign req_valid_o = (left_q != '0) && !outst_q && !mem_busy_i && room;
   assign req_addr_o  = next_q;
   assign outst_o     = outst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_q  <= '0;
         left_q  <= '0;
         outst_q <= 1'b0;
      end else if (load_i) begin
         next_q  <= first_i;
         left_q  <= {1'b0, last_i} - {1'b0, first_i} + (AW+1)'(1);
         outst_q <= 1'b0;
      end else begin
         if (req_valid_o) begin
            next_q  <= next_q + AW'(1);
            left_q  <= left_q - (AW+1)'(1);
            outst_q <= 1'b1;
         end else if (ack_i) begin
            outst_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/lpl_drainer.sv
module lpl_drainer #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] first_i,
   input  logic [AW-1:0] last_i,
   input  logic          en_i,
   input  logic          empty_i,
   output logic          wr_valid_o,
   output logic [AW-1:0] wr_addr_o,
   output logic          last_o
);
   logic [AW-1:0] addr_q;
   logic [AW:0]   left_q;

   assign wr_valid_o = en_i && !empty_i && (left_q != '0);
   assign wr_addr_o  = addr_q;
   assign last_o     = wr_valid_o && (left_q == (AW+1)'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         left_q <= '0;
      end else if (load_i) begin
         addr_q <= first_i;
         left_q <= {1'b0, last_i} - {1'b0, first_i} + (AW+1)'(1);
      end else if (wr_valid_o) begin
         addr_q <= addr_q + AW'(1);
         left_q <= left_q - (AW+1)'(1);
      end
   end
endmodule

// File: rtl/loop_prefetch_lock.sv
module loop_prefetch_lock
   import lpl_pkg::*;
#(
   parameter int AW        = 16,
   parameter int BLK_BYTES = 8,
   parameter int BUF_BYTES = 32,
   localparam int DW       = BLK_BYTES * 8,
   localparam int DEPTH    = BUF_BYTES / BLK_BYTES,
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] first_blk_i,
   input  logic [AW-1:0] last_blk_i,
   input  logic          mem_busy_i,
   output logic          req_valid_o,
   output logic [AW-1:0] req_addr_o,
   input  logic          rsp_valid_i,
   input  logic [DW-1:0] rsp_data_i,
   input  logic          assembled_i,
   input  logic          done_i,
   output logic          cwr_valid_o,
   output logic [AW-1:0] cwr_addr_o,
   output logic [DW-1:0] cwr_data_o,
   output logic          lock_en_o
);
   if (AW < 2) begin : g_bad_aw
      $error("loop_prefetch_lock: AW must be at least 2");
   end
   if (BLK_BYTES < 1 || BUF_BYTES < BLK_BYTES || (BUF_BYTES % BLK_BYTES) != 0) begin : g_bad_buf
      $error("loop_prefetch_lock: BUF_BYTES must be a whole multiple of BLK_BYTES");
   end
   if ((DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("loop_prefetch_lock: buffer depth must be a power of two");
   end

   lpl_state_e    state_q;
   logic          asm_q;
   logic          load;
   logic          outst;
   logic          push;
   logic          empty;
   logic          last_wr;
   logic [CW-1:0] buf_cnt;

   assign load      = start_i && (state_q == LPL_IDLE);
   assign push      = rsp_valid_i && outst;
   assign lock_en_o = (state_q == LPL_LOCK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LPL_IDLE;
         asm_q   <= 1'b0;
      end else begin
         case (state_q)
            LPL_IDLE: begin
               asm_q <= 1'b0;
               if (start_i) state_q <= LPL_FILL;
            end
            LPL_FILL: begin
               if (assembled_i) asm_q <= 1'b1;
               if (last_wr)     state_q <= LPL_LOCK;
            end
            LPL_LOCK: begin
               if (done_i) state_q <= LPL_IDLE;
            end
            default: state_q <= LPL_IDLE;
         endcase
      end
   end

   lpl_issuer #(.AW(AW), .DEPTH(DEPTH)) u_issuer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .first_i    (first_blk_i),
      .last_i     (last_blk_i),
      .mem_busy_i (mem_busy_i),
      .buf_cnt_i  (buf_cnt),
      .ack_i      (rsp_valid_i),
      .req_valid_o(req_valid_o),
      .req_addr_o (req_addr_o),
      .outst_o    (outst)
   );

   lpl_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (push),
      .din_i  (rsp_data_i),
      .pop_i  (cwr_valid_o),
      .dout_o (cwr_data_o),
      .empty_o(empty),
      .count_o(buf_cnt)
   );

   lpl_drainer #(.AW(AW)) u_drain (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (load),
      .first_i   (first_blk_i),
      .last_i    (last_blk_i),
      .en_i      (asm_q && (state_q == LPL_FILL)),
      .empty_i   (empty),
      .wr_valid_o(cwr_valid_o),
      .wr_addr_o (cwr_addr_o),
      .last_o    (last_wr)
   );
endmodule

// File: rtl/lpl_chk.sv
module lpl_chk (
   input logic clk,
   input logic rst_n,
   input logic mem_busy_i,
   input logic req_valid_o,
   input logic cwr_valid_o,
   input logic done_i,
   input logic lock_en_o
);
   // R3
   no_busy_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |-> !mem_busy_i);
   // R3
   single_outst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_o |=> !req_valid_o);
   // R7
   lock_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lock_en_o) |-> $past(cwr_valid_o));
   // R5
   no_write_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_en_o |-> !cwr_valid_o);
   // R8
   unlock_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lock_en_o) |-> $past(done_i));
   // R8
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_en_o && !done_i) |=> lock_en_o);
   // R9
   no_req_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_en_o |-> !req_valid_o);
endmodule

bind loop_prefetch_lock lpl_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mem_busy_i (mem_busy_i),
   .req_valid_o(req_valid_o),
   .cwr_valid_o(cwr_valid_o),
   .done_i     (done_i),
   .lock_en_o  (lock_en_o)
);

// File: tb/loop_prefetch_lock_bench.sv
module loop_prefetch_lock_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [15:0] first_blk_i = '0;
   logic [15:0] last_blk_i = '0;
   logic        mem_busy_i = 1'b0;
   logic        req_valid_o;
   logic [15:0] req_addr_o;
   logic        rsp_valid_i = 1'b0;
   logic [63:0] rsp_data_i = '0;
   logic        assembled_i = 1'b0;
   logic        done_i = 1'b0;
   logic        cwr_valid_o;
   logic [15:0] cwr_addr_o;
   logic [63:0] cwr_data_o;
   logic        lock_en_o;

   loop_prefetch_lock u_loop_prefetch_lock (.*);

   always #10 clk = ~clk;

   int chk_n = 0, fail_n = 0, cyc = 0;
   int busy_pct = 0;
   bit drv_start = 0, drv_asm = 0, drv_done = 0;
   logic [15:0] drv_first = '0, drv_last = '0;
   logic [15:0] last_q, exp_req, exp_wr, rsp_addr;
   int issued, written, pushed, rsp_cnt;
   bit pend = 0, asm_seen_exp = 0, lock_exp = 0, lock_next = 0, rsp_now = 0;

   function automatic logic [63:0] mdata(logic [15:0] a);
      logic [15:0] h;
      h = a * 16'h9e37;
      return {a ^ 16'h5a5a, ~a, a, h};
   endfunction

   task automatic check(bit ok, string req, longint act, longint exp);
      chk_n++;
      if (!ok) begin
         fail_n++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", chk_n - fail_n, chk_n);
      $finish;
   endtask

   task automatic step();
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
         check(0, "watchdog", cyc, 150000);
         summary();
      end
      start_i     = drv_start;
      first_blk_i = drv_first;
      last_blk_i  = drv_last;
      assembled_i = drv_asm;
      done_i      = drv_done;
      mem_busy_i  = (($urandom % 100) < busy_pct);
      rsp_now = 0;
      if (rsp_cnt > 0) begin
         rsp_cnt--;
         if (rsp_cnt == 0 && pend) rsp_now = 1;
      end
      rsp_valid_i = rsp_now;
      rsp_data_i  = rsp_now ? mdata(rsp_addr) : 64'h0;
      #1;
      if (req_valid_o) begin
         check(!mem_busy_i, "R3 request while memory busy", 1, 0);
         check(!pend && !rsp_now, "R3 second outstanding request", 1, 0);
         check((pushed - written) < 4, "R4 buffer occupancy at request", pushed - written, 3);
         check(req_addr_o == exp_req, "R2 request address", req_addr_o, exp_req);
         exp_req++;
         issued++;
      end
      if (cwr_valid_o) begin
         check(asm_seen_exp, "R5 cache write before assembly", 1, 0);
         check(cwr_addr_o == exp_wr, "R5 write address", cwr_addr_o, exp_wr);
         check(cwr_data_o == mdata(exp_wr), "R5 write data", cwr_data_o, mdata(exp_wr));
         if (exp_wr == last_q) lock_next = 1;
         exp_wr++;
         written++;
      end
      check(lock_en_o == lock_exp, "R7 R8 lock_en_o", lock_en_o, lock_exp);
      if (rsp_now) begin
         pend = 0;
         pushed++;
      end
      if (req_valid_o) begin
         pend = 1;
         rsp_addr = req_addr_o;
         rsp_cnt = 1 + ($urandom % 3);
      end
      if (drv_asm && !lock_exp) asm_seen_exp = 1;
      if (drv_done && lock_exp) lock_exp = 0;
      if (lock_next) begin
         lock_exp = 1;
         lock_next = 0;
      end
   endtask

   task automatic run_loop(logic [15:0] f, logic [15:0] l, int asm_wait, int pct, bit mid);
      int len;
      len = int'(l) - int'(f) + 1;
      busy_pct = pct;
      last_q = l; exp_req = f; exp_wr = f;
      issued = 0; written = 0; pushed = 0; asm_seen_exp = 0;
      drv_first = f; drv_last = l; drv_start = 1;
      step();
      drv_start = 0;
      for (int n = 0; n < 4000 && !lock_exp; n++) begin
         if (n == asm_wait) drv_asm = 1;
         if (mid && n == 2) begin
            drv_start = 1; drv_first = 16'h0700; drv_last = 16'h0702;
         end else begin
            drv_start = 0;
         end
         if (asm_wait >= 20 && n == asm_wait - 1) begin
            // R4: buffer fills and requests stop before assembly
            check(issued == (len < 4 ? len : 4), "R4 requests before assembly", issued, (len < 4 ? len : 4));
            check(written == 0, "R5 no writes before assembly", written, 0);
         end
         step();
      end
      check(lock_exp, "R7 lock reached", lock_exp, 1);
      check(issued == len, "R2 request count", issued, len);
      check(written == len, "R6 all blocks written", written, len);
      // R9: start while locked is ignored
      drv_start = 1; drv_first = 16'h0900; drv_last = 16'h0903;
      step();
      drv_start = 0;
      for (int k = 0; k < 3; k++) begin
         step();
         check(!req_valid_o && lock_en_o, "R9 start ignored while locked", req_valid_o, 0);
      end
      drv_done = 1;
      step();
      drv_done = 0; drv_asm = 0;
      step();
      check(!lock_en_o, "R8 lock cleared after done", lock_en_o, 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rsp_cnt = 0;
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state
      check(!req_valid_o && !cwr_valid_o && !lock_en_o, "R1 reset outputs", {req_valid_o, cwr_valid_o, lock_en_o}, 0);
      rst_n = 1'b1;
      step();
      check(!req_valid_o && !lock_en_o, "R1 idle after reset", {req_valid_o, lock_en_o}, 0);
      // R4 R6: long assembly wait, range of twice the buffer
      run_loop(16'h0100, 16'h0107, 30, 0, 0);
      // R10: single block
      run_loop(16'h0020, 16'h0020, 0, 0, 0);
      // R9: start pulse during prefetch
      run_loop(16'h0300, 16'h0309, 5, 30, 1);
      // R2: top of address space
      run_loop(16'hfffa, 16'hffff, 3, 20, 0);
      // R10: single block with late assembly
      run_loop(16'h1234, 16'h1234, 25, 50, 0);
      for (int r = 0; r < 8; r++) begin
         logic [15:0] f;
         int ln;
         f  = 16'($urandom % 16'hff00);
         ln = 1 + ($urandom % 12);
         run_loop(f, f + 16'(ln - 1), $urandom % 16, $urandom % 61, r[0]);
      end
      summary();
   end
endmodule